// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and Idle Detection

This block receives character-framed asynchronous serial data on a single input line. A bit-rate enable that runs at sixteen times the bit rate drives it. The receiver locks onto the falling edge of each start bit. It checks that the start bit is still low at the middle of its cell. It then samples every following cell at its centre: the data bits, the optional parity bit and one or two stop bits. Each accepted character is offered on a valid/ready output. If a newer character arrives before the older one is taken, the newer one replaces it.

Five conditions are recorded as sticky event flags, each cleared by writing 1 to its clear input:
- a parity mismatch;
- a stop bit read low;
- a line held low for a whole character frame (break);
- the return of the line to high after a break;
- an idle period lasting a programmed number of character times.

A per-flag mask decides which flags drive the single interrupt output. Character length, parity mode, stop-bit count and the idle limit are static configuration inputs.

Top module: `serial_rx_brk`

## Requirements
- R1: A character starts only on a high-to-low transition of the line. If the line reads high at the middle of the start cell (eighth oversample tick), the attempt is dropped and produces no character and no flag.
- R2: Data bits arrive least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `m_data` is right-justified, with unused upper bits zero.
- R3: `cfg_par` selects parity: 2'b01 means even, 2'b10 means odd, and 2'b00 or 2'b11 means no parity bit. A received parity bit that does not match sets flag bit 0 in the same cycle that the character is offered.
- R4: `cfg_two_stop`=1 selects two stop bits and 0 selects one. If any stop bit samples low, flag bit 1 is set, and the character is still offered.
- R5: If the start bit, every data bit, the parity bit (if enabled) and every stop bit all sample low, flag bit 2 is set and no character is offered. After that, no further character or break event occurs until the line has been seen high again.
- R6: The first high level on the line after a break sets flag bit 3.
- R7: With `cfg_to_en`=1, flag bit 4 is set once the receiver has been idle, with no line edge, for `cfg_to_chars` character times. A character time is the length of a full frame for the current configuration. Any line edge and any received character restart the count. With `cfg_to_en`=0 the flag is never set, and a limit of 0 disables the timer.
- R8: Every flag stays set until its bit of `ev_clr` is 1 in some cycle. If a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some flag is set whose `ev_mask` bit is 0. A masked flag still sets.
- R10: `m_valid` stays high until a cycle with `m_ready` high. A character that arrives while `m_valid` is high replaces `m_data`.
- R11: The timing of each character comes only from its own start edge and the `os_tick` enables. Reception is correct when `os_tick` is high on only every second cycle and when gaps between characters vary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idles high |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par | input | 2 | Parity mode (01 even, 10 odd, else none) |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_to_en | input | 1 | Idle timeout event enable |
| cfg_to_chars | input | 8 | Idle limit in character times (0 = off) |
| m_valid | output | 1 | Received character available |
| m_data | output | 8 | Received character |
| m_ready | input | 1 | Consumer takes the character |
| ev_clr | input | 5 | Write-1-to-clear per flag |
| ev_mask | input | 5 | 1 = flag kept off the interrupt |
| ev_flags | output | 5 | Sticky flags: 0 parity, 1 framing, 2 break, 3 break end, 4 timeout |
| irq | output | 1 | Interrupt, any unmasked flag |

## Verification
The one collision in this block is a new event arriving in the same cycle that the host clears the same flag. The parity flag shows it most clearly. The bench holds the parity clear bit high throughout a character whose parity is wrong, and drops it on the first sample after `m_valid` rises. The flag must then read 1, because set has priority over clear. A related overlap is a character that carries both parity and framing errors, so that two flags set in one cycle. The random stream produces this case and checks the whole flag vector.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W  = 8;
    localparam int N_EV    = 5;
    localparam int EV_PAR  = 0;
    localparam int EV_FRM  = 1;
    localparam int EV_BRK  = 2;
    localparam int EV_BEND = 3;
    localparam int EV_TMO  = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_char_t;

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == 2'b01) || (mode == 2'b10);
    endfunction

    // whole frame length in bit cells: start + data + parity + stops
    function automatic logic [3:0] frame_cells(input logic [1:0] len_code,
                                               input logic [1:0] mode,
                                               input logic       two);
        return 4'd7 + {2'b00, len_code} + {3'b000, par_on(mode)} + {3'b000, two};
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall,
    output logic edge_any
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign dout     = chain[STAGES-1];
    assign fall     = prev & ~chain[STAGES-1];
    assign edge_any = prev ^ chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       rx_fall,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_two_stop,
    output logic       char_vld,
    output rx_char_t   char_q,
    output logic       brk_set,
    output logic       brk_end,
    output logic       idle,
    output logic       in_brk
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] HALF = CW'(OS/2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OS - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bitn;
    logic [DATA_W-1:0] sh;
    logic              par_acc, zeros, ferr, perr, stopn;
    logic              mid, stop_z, stop_f, last_stop;
    logic [2:0]        last_bit;

    always_comb begin
        mid       = tick && (cnt == FULL);
        stop_z    = zeros & ~rx_s;
        stop_f    = ferr | ~rx_s;
        last_stop = (stopn == cfg_two_stop);
        last_bit  = 3'd4 + {1'b0, cfg_len};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            sh       <= '0;
            par_acc  <= 1'b0;
            zeros    <= 1'b0;
            ferr     <= 1'b0;
            perr     <= 1'b0;
            stopn    <= 1'b0;
            char_vld <= 1'b0;
            char_q   <= '0;
            brk_set  <= 1'b0;
            brk_end  <= 1'b0;
        end else begin
            char_vld <= 1'b0;
            brk_set  <= 1'b0;
            brk_end  <= 1'b0;
            unique case (state)
                ST_IDLE: if (rx_fall) begin
                    state <= ST_START;
                    cnt   <= '0;
                end
                ST_START: if (tick) begin
                    if (cnt == HALF) begin
                        cnt <= '0;
                        if (rx_s) state <= ST_IDLE;
                        else begin
                            state   <= ST_DATA;
                            bitn    <= '0;
                            zeros   <= 1'b1;
                            par_acc <= 1'b0;
                            ferr    <= 1'b0;
                            perr    <= 1'b0;
                            stopn   <= 1'b0;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) begin
                        sh      <= {rx_s, sh[DATA_W-1:1]};
                        par_acc <= par_acc ^ rx_s;
                        zeros   <= zeros & ~rx_s;
                        if (bitn == last_bit)
                            state <= par_on(cfg_par) ? ST_PAR : ST_STOP;
                        else
                            bitn <= bitn + 1'b1;
                    end
                end
                ST_PAR: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) begin
                        perr  <= par_acc ^ rx_s ^ (cfg_par == 2'b10);
                        zeros <= zeros & ~rx_s;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (mid) begin
                        if (!last_stop) begin
                            zeros <= stop_z;
                            ferr  <= stop_f;
                            stopn <= 1'b1;
                        end else if (stop_z) begin
                            brk_set <= 1'b1;
                            state   <= ST_BRK;
                        end else begin
                            char_vld    <= 1'b1;
                            char_q.data <= sh >> (2'd3 - cfg_len);
                            char_q.perr <= perr;
                            char_q.ferr <= stop_f;
                            state       <= ST_IDLE;
                        end
                    end
                end
                ST_BRK: if (rx_s) begin
                    brk_end <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle   = (state == ST_IDLE);
    assign in_brk = (state == ST_BRK);
endmodule

// File: rtl/srx_idle_timer.sv
module srx_idle_timer #(
    parameter int OS    = 16,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             idle,
    input  logic             restart,
    input  logic [3:0]       cells,
    input  logic [LIM_W-1:0] limit,
    input  logic             en,
    output logic             tmo
);
    localparam int TW = $clog2(12 * OS) + 1;

    logic [TW-1:0]    tcnt, per_char;
    logic [LIM_W-1:0] ccnt;
    logic             armed;

    assign per_char = TW'(cells) * TW'(OS);

    always_ff @(posedge clk) begin
        tmo <= 1'b0;
        if (rst || restart || !idle) begin
            tcnt  <= '0;
            ccnt  <= '0;
            armed <= 1'b1;
        end else if (tick && armed && (limit != '0)) begin
            if (tcnt == per_char - 1'b1) begin
                tcnt <= '0;
                if (ccnt == limit - 1'b1) begin
                    armed <= 1'b0;
                    tmo   <= en;
                    ccnt  <= '0;
                end else ccnt <= ccnt + 1'b1;
            end else tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/srx_events.sv
module srx_events #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & ~mask);
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int LIM_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    input  logic              cfg_to_en,
    input  logic [LIM_W-1:0]  cfg_to_chars,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready,
    input  logic [N_EV-1:0]   ev_clr,
    input  logic [N_EV-1:0]   ev_mask,
    output logic [N_EV-1:0]   ev_flags,
    output logic              irq
);
    logic      rx_s, rx_fall, rx_edge;
    logic      char_vld, brk_set, brk_end, idle, in_brk, tmo;
    rx_char_t  char_q;
    logic [N_EV-1:0] ev_set;

    srx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rxd),
        .dout(rx_s), .fall(rx_fall), .edge_any(rx_edge)
    );

    srx_framer #(.OS(OS_RATE)) u_frm (
        .clk(clk), .rst(rst), .tick(os_tick), .rx_s(rx_s), .rx_fall(rx_fall),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .char_vld(char_vld), .char_q(char_q), .brk_set(brk_set),
        .brk_end(brk_end), .idle(idle), .in_brk(in_brk)
    );

    srx_idle_timer #(.OS(OS_RATE), .LIM_W(LIM_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(os_tick), .idle(idle),
        .restart(rx_edge | char_vld),
        .cells(frame_cells(cfg_len, cfg_par, cfg_two_stop)),
        .limit(cfg_to_chars), .en(cfg_to_en), .tmo(tmo)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[EV_PAR]  = char_vld & char_q.perr;
        ev_set[EV_FRM]  = char_vld & char_q.ferr;
        ev_set[EV_BRK]  = brk_set;
        ev_set[EV_BEND] = brk_end;
        ev_set[EV_TMO]  = tmo;
    end

    srx_events #(.N(N_EV)) u_ev (
        .clk(clk), .rst(rst), .set(ev_set), .clr(ev_clr), .mask(ev_mask),
        .flags(ev_flags), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_data  <= '0;
        end else if (char_vld) begin
            m_valid <= 1'b1;
            m_data  <= char_q.data;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
    input logic       clk,
    input logic       rst,
    input logic       m_valid,
    input logic       m_ready,
    input logic [4:0] ev_flags,
    input logic [4:0] ev_clr,
    input logic [4:0] ev_mask,
    input logic       irq,
    input logic       in_brk,
    input logic       cfg_to_en
);
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> m_valid); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ev_flags & $past(ev_flags & ~ev_clr)) == $past(ev_flags & ~ev_clr))); // R8

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&ev_mask) |-> !irq); // R9

    AST_NO_CHAR_IN_BREAK: assert property (@(posedge clk) disable iff (rst)
        in_brk |=> !$rose(m_valid)); // R5

    AST_BREAK_END_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_flags[3]) |-> $past(in_brk, 2)); // R6

    AST_TIMEOUT_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_flags[4]) |-> cfg_to_en); // R7
endmodule

bind serial_rx_brk srx_chk u_chk (
    .clk(clk), .rst(rst), .m_valid(m_valid), .m_ready(m_ready),
    .ev_flags(ev_flags), .ev_clr(ev_clr), .ev_mask(ev_mask), .irq(irq),
    .in_brk(in_brk), .cfg_to_en(cfg_to_en)
);

// File: tb/sim_serial_rx_brk.sv
module sim_serial_rx_brk;
    logic       clk = 1'b0;
    logic       rst, os_tick, rxd, cfg_two_stop, cfg_to_en, m_valid, m_ready, irq;
    logic [1:0] cfg_len, cfg_par;
    logic [7:0] cfg_to_chars, m_data;
    logic [4:0] ev_clr, ev_mask, ev_flags;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 1;
    int ph     = 0;

    always #5 clk = ~clk;

    serial_rx_brk u0 (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .cfg_to_en(cfg_to_en), .cfg_to_chars(cfg_to_chars),
        .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
        .ev_clr(ev_clr), .ev_mask(ev_mask), .ev_flags(ev_flags), .irq(irq)
    );

    initial begin
        os_tick = 1'b1;
        forever begin
            @(negedge clk);
            ph      = (ph + 1 >= tdiv) ? 0 : ph + 1;
            os_tick = (ph == 0);
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mask_len(input logic [7:0] d, input int len);
        return d & 8'((1 << len) - 1);
    endfunction

    function automatic logic par_bit(input logic [7:0] dm, input logic [1:0] mode);
        return (mode == 2'b10) ? ~^dm : ^dm;
    endfunction

    // one frame on the line; relclr drops ev_clr once m_valid is seen
    task automatic send(input logic [7:0] d, input int len, input logic [1:0] mode,
                        input bit two, input bit bpar, input bit bstop, input bit relclr);
        int bitc;
        logic [7:0] dm;
        bitc = 16 * tdiv;
        dm   = mask_len(d, len);
        cfg_len = 2'(len - 5); cfg_par = mode; cfg_two_stop = two;
        rxd = 1'b0; wait_cyc(bitc);
        for (int i = 0; i < len; i++) begin rxd = dm[i]; wait_cyc(bitc); end
        if (mode == 2'b01 || mode == 2'b10) begin
            rxd = par_bit(dm, mode) ^ bpar; wait_cyc(bitc);
        end
        for (int s = 0; s < (two ? 2 : 1); s++) begin
            rxd = (s == 0) ? ~bstop : 1'b1;
            for (int c = 0; c < bitc; c++) begin
                @(negedge clk);
                if (relclr && m_valid) ev_clr = '0;
            end
        end
        rxd = 1'b1;
    endtask

    task automatic take();
        m_ready = 1'b1; @(negedge clk); m_ready = 1'b0;
    endtask

    task automatic clear_all();
        ev_clr = '1; @(negedge clk); ev_clr = '0;
    endtask

    task automatic expect_char(input logic [7:0] exp, input logic [4:0] fl, input string req);
        chk(m_valid === 1'b1, {req, " m_valid"}, int'(m_valid), 1);
        chk(m_data === exp, {req, " m_data"}, int'(m_data), int'(exp));
        chk(ev_flags === fl, {req, " flags"}, int'(ev_flags), int'(fl));
        take();
        clear_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, dm;
        int len;
        logic [1:0] mode;
        bit two, bp, bs;
        void'($urandom(32'h5eed1234));
        rst = 1'b1; rxd = 1'b1; m_ready = 1'b0; ev_clr = '0; ev_mask = '0;
        cfg_len = 2'd3; cfg_par = 2'b00; cfg_two_stop = 1'b0;
        cfg_to_en = 1'b0; cfg_to_chars = 8'd3;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        chk(m_valid === 1'b0, "R10 reset m_valid", int'(m_valid), 0);
        chk(ev_flags === 5'd0, "R8 reset flags", int'(ev_flags), 0);
        chk(irq === 1'b0, "R9 reset irq", int'(irq), 0);
        wait_cyc(40);

        // R2 directed: five bits, upper bits zero
        send(8'hF5, 5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_char(8'h15, 5'd0, "R2 len5");
        wait_cyc(20);

        // R1 glitch shorter than half a cell
        rxd = 1'b0; wait_cyc(5); rxd = 1'b1;
        wait_cyc(200);
        chk(m_valid === 1'b0, "R1 glitch no char", int'(m_valid), 0);
        chk(ev_flags === 5'd0, "R1 glitch no flag", int'(ev_flags), 0);

        // random stream (R2 R3 R4)
        for (int n = 0; n < 40; n++) begin
            d    = 8'($urandom);
            len  = 5 + int'($urandom_range(0, 3));
            mode = 2'($urandom);
            two  = 1'($urandom);
            bp   = ($urandom_range(0, 3) == 0) && (mode == 2'b01 || mode == 2'b10);
            bs   = ($urandom_range(0, 3) == 0);
            dm   = mask_len(d, len);
            if (dm == 8'd0) bs = 1'b0;
            send(d, len, mode, two, bp, bs, 1'b0);
            expect_char(dm, {3'b000, bs, bp}, "R3 R4 random");
            wait_cyc(int'($urandom_range(0, 40)));
        end

        // R4 two stops, second stop low is not applied; first stop low flagged
        send(8'hA7, 8, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_char(8'hA7, 5'b00010, "R4 two-stop ferr");

        // R10 hold and overwrite
        send(8'h3C, 8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_cyc(50);
        chk(m_valid === 1'b1 && m_data === 8'h3C, "R10 held", int'(m_data), 'h3C);
        send(8'hC3, 8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(m_data === 8'hC3, "R10 overwrite", int'(m_data), 'hC3);
        take();
        chk(m_valid === 1'b0, "R10 taken", int'(m_valid), 0);
        wait_cyc(20);

        // R9 mask
        ev_mask = '1;
        send(8'h81, 8, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(ev_flags[0] === 1'b1, "R9 masked flag sets", int'(ev_flags), 1);
        chk(irq === 1'b0, "R9 masked irq", int'(irq), 0);
        ev_mask = 5'b11110; @(negedge clk);
        chk(irq === 1'b1, "R9 unmasked irq", int'(irq), 1);
        ev_mask = '0;
        take(); clear_all();
        chk(irq === 1'b0, "R8 cleared", int'(irq), 0);

        // R8 set wins over clear in the same cycle
        ev_clr = 5'b00001;
        send(8'h55, 8, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1);
        ev_clr = '0;
        wait_cyc(2);
        chk(ev_flags[0] === 1'b1, "R8 set beats clear", int'(ev_flags), 1);
        take(); clear_all();
        wait_cyc(20);

        // R5 R6 break
        cfg_len = 2'd3; cfg_par = 2'b01; cfg_two_stop = 1'b0;
        rxd = 1'b0; wait_cyc(16 * 13);
        chk(ev_flags === 5'b00100, "R5 break flag", int'(ev_flags), 'h4);
        chk(m_valid === 1'b0, "R5 break no char", int'(m_valid), 0);
        clear_all();
        wait_cyc(16 * 30);
        chk(ev_flags === 5'd0, "R5 no repeat in break", int'(ev_flags), 0);
        chk(m_valid === 1'b0, "R5 no char in break", int'(m_valid), 0);
        rxd = 1'b1; wait_cyc(6);
        chk(ev_flags === 5'b01000, "R6 break end", int'(ev_flags), 'h8);
        clear_all();
        wait_cyc(20);

        // R7 timeout: 8N1 is 160 ticks per char, limit 3
        cfg_to_en = 1'b1; cfg_to_chars = 8'd3;
        send(8'h5A, 8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        take(); clear_all();
        wait_cyc(300);
        chk(ev_flags[4] === 1'b0, "R7 no early timeout", int'(ev_flags), 0);
        wait_cyc(250);
        chk(ev_flags[4] === 1'b1, "R7 timeout", int'(ev_flags), 'h10);
        clear_all();
        wait_cyc(600);
        chk(ev_flags[4] === 1'b0, "R7 single event", int'(ev_flags), 0);
        cfg_to_en = 1'b0;
        rxd = 1'b0; wait_cyc(3); rxd = 1'b1;
        wait_cyc(700);
        chk(ev_flags[4] === 1'b0, "R7 disabled", int'(ev_flags), 0);

        // R11 slower tick, varied gaps
        tdiv = 2;
        wait_cyc(10);
        send(8'h96, 8, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_char(8'h96, 5'd0, "R11 half tick a");
        wait_cyc(7);
        send(8'h2B, 7, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_char(8'h2B, 5'd0, "R11 half tick b");
        wait_cyc(61);
        send(8'hE1, 6, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_char(8'h21, 5'd0, "R11 half tick c");

        summary();
        $finish;
    end
endmodule